// File: doc/BRIEF.md
# Read Data Latency Pipeline with Byte Masking

This block sits between the storage array of a synchronous graphics memory and its 32-bit data bus on the read path. A read beat that the array presents together with a valid strobe leaves on the bus after a programmed latency of two or three clocks. Each byte lane has its own output enable. A byte is switched off when its mask input was high two clocks before the edge at which the controller samples that beat. Holding the clock-enable input low freezes every register in the path, so the whole read stream stretches by one cycle for each suspended edge.

The latency setting is a one-bit code. It is adopted only while the pipeline holds no beat, so a read that is in flight never changes timing partway through. Command decoding and the bidirectional pad are handled elsewhere. This block drives the outgoing data and the per-byte enables that a pad wrapper would use.

Top module: `rd_lat_pipe`

## Requirements
- R1: With latency code 0 (latency 2), a beat captured at an active edge (`cke`=1, `rd_valid`=1) is on `bus_data` right after the next active edge, so the controller samples it at the second active edge after capture.
- R2: With latency code 1 (latency 3), a captured beat is on `bus_data` right after the second active edge that follows the capture edge.
- R3: A high `byte_mask[i]` at an active edge forces `byte_oe[i]` low and `bus_data[8i+7:8i]` to zero for the output present after the next active edge, which is the output the controller samples two active edges after the mask. This holds at either latency.
- R4: An edge with `cke` low has no effect. Outputs, the stored beats, the stored mask and the latency all hold, and `rd_valid`, `rd_data` and `byte_mask` at that edge are discarded.
- R5: Beats captured on consecutive active edges come out on consecutive cycles with no gap and in order.
- R6: `lat_sel` is adopted at an active edge only when no beat was captured at either of the two preceding active edges. The new value already applies to a beat captured at that same edge. A change made while beats are in flight waits until this condition holds.
- R7: While no beat is due, `byte_oe` is 0 and `bus_data` is 0. An unmasked beat drives `byte_oe` to all ones and carries its data unchanged.
- R8: Synchronous active-high `rst` clears `byte_oe` and `bus_data`, empties the pipeline and selects latency 2 until the first active edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable; low suspends the edge |
| rd_valid | input | 1 | Array read beat present this edge |
| rd_data | input | 32 | Read data from the array |
| byte_mask | input | 4 | Per-byte read mask, one bit per 8-bit lane |
| lat_sel | input | 1 | Latency code: 0 selects 2, 1 selects 3 |
| bus_data | output | 32 | Registered outgoing data, masked lanes zero |
| byte_oe | output | 4 | Registered per-byte output enable |

## Verification
A stage valid bit that is stuck or shifted shows up within two active edges as an enable pulse that comes a cycle early or late, is missing, or is repeated. A stale mask register shows up as the wrong lane switched off on the very next beat. A latency register that changes while a beat is in flight makes that beat appear twice or vanish, at most three edges later. A clock enable that is not fully honored shows up as outputs that move after a suspended edge. The bench follows the active-edge count independently, so each of these faults becomes a cycle-level mismatch.

// File: rtl/rdp_pkg.sv
package rdp_pkg;
  localparam int unsigned BUS_W   = 32;
  localparam int unsigned LANE_W  = 8;
  localparam int unsigned LAT_MIN = 2;
  localparam int unsigned LAT_MAX = 3;
endpackage

// File: rtl/rdp_beat_chain.sv
// Shift chain of read beats; stage s holds a beat captured s+1 active edges ago.
module rdp_beat_chain #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      adv,
  input  logic                      beat_v,
  input  logic [DW-1:0]             beat_d,
  output logic [DEPTH-1:0]          st_v,
  output logic [DEPTH-1:0][DW-1:0]  st_d
);
  generate
    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
      logic          nv;
      logic [DW-1:0] nd;
      logic          v_q;
      logic [DW-1:0] d_q;
      if (s == 0) begin : g_head
        assign nv = beat_v;
        assign nd = beat_d;
      end else begin : g_tail
        assign nv = st_v[s-1];
        assign nd = st_d[s-1];
      end
      always_ff @(posedge clk) begin
        if (rst) v_q <= 1'b0;
        else if (adv) v_q <= nv;
      end
      always_ff @(posedge clk) begin
        if (adv) d_q <= nd;
      end
      assign st_v[s] = v_q;
      assign st_d[s] = d_q;
    end
  endgenerate

  // R4: a suspended edge leaves the head stage untouched
  a_r4_chain_hold: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(st_v[0]));
endmodule

// File: rtl/rdp_mask_stage.sv
// Holds the byte masks of the last active edge.
module rdp_mask_stage #(
  parameter int unsigned NB = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic [NB-1:0] mask_in,
  output logic [NB-1:0] mask_q
);
  always_ff @(posedge clk) begin
    if (rst) mask_q <= '0;
    else if (adv) mask_q <= mask_in;
  end
endmodule

// File: rtl/rdp_lat_ctrl.sv
// Latency register, updated only while the chain is empty.
module rdp_lat_ctrl #(
  parameter int unsigned SEL_W = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic             busy,
  input  logic [SEL_W-1:0] lat_sel,
  output logic [SEL_W-1:0] lat_q
);
  always_ff @(posedge clk) begin
    if (rst) lat_q <= '0;
    else if (adv && !busy) lat_q <= lat_sel;
  end

  // R6: the setting cannot move while a beat is held or the edge is suspended
  a_r6_lat_hold: assert property (@(posedge clk) disable iff (rst)
    (busy || !adv) |=> $stable(lat_q));
endmodule

// File: rtl/rd_lat_pipe.sv
module rd_lat_pipe #(
  parameter int unsigned DW      = rdp_pkg::BUS_W,
  parameter int unsigned LANE    = rdp_pkg::LANE_W,
  parameter int unsigned MIN_LAT = rdp_pkg::LAT_MIN,
  parameter int unsigned MAX_LAT = rdp_pkg::LAT_MAX,
  localparam int unsigned NB     = DW / LANE,
  localparam int unsigned SEL_W  = (MAX_LAT > MIN_LAT) ? $clog2(MAX_LAT - MIN_LAT + 1) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cke,
  input  logic             rd_valid,
  input  logic [DW-1:0]    rd_data,
  input  logic [NB-1:0]    byte_mask,
  input  logic [SEL_W-1:0] lat_sel,
  output logic [DW-1:0]    bus_data,
  output logic [NB-1:0]    byte_oe
);
  localparam int unsigned DEPTH = MAX_LAT - 1;

  logic [DEPTH-1:0]         st_v;
  logic [DEPTH-1:0][DW-1:0] st_d;
  logic [NB-1:0]            mask_q;
  logic [SEL_W-1:0]         lat_q;
  logic                     busy;
  logic                     tap_v;
  logic [DW-1:0]            tap_d;
  logic [NB-1:0]            lane_on;
  logic [DW-1:0]            lane_d;

  rdp_beat_chain #(.DW(DW), .DEPTH(DEPTH)) u_chain (
    .clk(clk), .rst(rst), .adv(cke),
    .beat_v(rd_valid), .beat_d(rd_data),
    .st_v(st_v), .st_d(st_d)
  );

  rdp_mask_stage #(.NB(NB)) u_mask (
    .clk(clk), .rst(rst), .adv(cke),
    .mask_in(byte_mask), .mask_q(mask_q)
  );

  assign busy = |st_v;

  rdp_lat_ctrl #(.SEL_W(SEL_W)) u_lat (
    .clk(clk), .rst(rst), .adv(cke), .busy(busy),
    .lat_sel(lat_sel), .lat_q(lat_q)
  );

  // Tap the stage that matches the active latency.
  always_comb begin
    tap_v = 1'b0;
    tap_d = '0;
    for (int s = 0; s < int'(DEPTH); s++) begin
      if (s == int'(lat_q) + int'(MIN_LAT) - 2) begin
        tap_v = st_v[s];
        tap_d = st_d[s];
      end
    end
  end

  generate
    for (genvar b = 0; b < NB; b++) begin : g_lane
      assign lane_on[b]               = tap_v & ~mask_q[b];
      assign lane_d[b*LANE +: LANE]   = lane_on[b] ? tap_d[b*LANE +: LANE] : '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      byte_oe  <= '0;
      bus_data <= '0;
    end else if (cke) begin
      byte_oe  <= lane_on;
      bus_data <= lane_d;
    end
  end

  // R4: outputs freeze across a suspended edge
  a_r4_suspend_hold: assert property (@(posedge clk) disable iff (rst)
    !cke |=> ($stable(bus_data) && $stable(byte_oe)));

  // R3: a mask two active edges back switches its lane off
  generate
    for (genvar b = 0; b < NB; b++) begin : g_mchk
      a_r3_mask_kills: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst, 2) && !$past(rst) && $past(cke, 2) && $past(cke) && $past(byte_mask[b], 2))
        |-> !byte_oe[b]);
    end
  endgenerate

  // R1: an unmasked beat at minimum latency is fully enabled one active edge later
  a_r1_short_beat: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst, 2) && !$past(rst) && $past(cke, 2) && $past(cke) && $past(rd_valid, 2)
     && ($past(lat_q) == '0) && ($past(byte_mask, 2) == '0))
    |-> (byte_oe == '1));
endmodule

// File: tb/rd_lat_pipe_tb.sv
`timescale 1ns/1ps
module rd_lat_pipe_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        cke;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic [3:0]  byte_mask;
  logic [0:0]  lat_sel;
  logic [31:0] bus_data;
  logic [3:0]  byte_oe;

  always #2 clk = ~clk;

  rd_lat_pipe u_dut (
    .clk(clk), .rst(rst), .cke(cke), .rd_valid(rd_valid), .rd_data(rd_data),
    .byte_mask(byte_mask), .lat_sel(lat_sel), .bus_data(bus_data), .byte_oe(byte_oe)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  string phase = "R8";

  // independent model indexed by active-edge count
  int          k;
  int          lcur;
  int          nbeat;
  bit          capv [0:4095];
  bit          sv   [0:4095];
  logic [31:0] sd   [0:4095];
  logic [3:0]  ma   [0:4095];
  logic [31:0] exp_d;
  logic [3:0]  exp_oe;

  task automatic check(input string tag, input logic [31:0] d, input logic [3:0] oe);
    n_chk++;
    if (bus_data !== d || byte_oe !== oe) begin
      n_bad++;
      $display("FAIL %s k=%0d: bus_data=%h byte_oe=%b expected %h %b", tag, k, bus_data, byte_oe, d, oe);
    end
  endtask

  task automatic step(input logic c, input logic rv, input logic [3:0] m, input logic ls);
    logic [31:0] dat;
    dat = 32'h9E3779B1 * nbeat + 32'h0135_7913;
    cke = c; rd_valid = rv; rd_data = dat; byte_mask = m; lat_sel = ls;
    if (rv) nbeat++;
    @(posedge clk);
    if (c) begin
      k++;
      capv[k] = rv;
      ma[k]   = m;
      if (!capv[k-1] && !capv[k-2]) lcur = 2 + int'(ls);   // R6
      if (rv) begin
        sv[k+lcur-1] = 1'b1;
        sd[k+lcur-1] = dat;
      end
      exp_oe = sv[k] ? ~ma[k-1] : 4'h0;
      for (int b = 0; b < 4; b++)
        exp_d[b*8 +: 8] = exp_oe[b] ? sd[k][b*8 +: 8] : 8'h00;
    end
    @(negedge clk);
    check(c ? phase : {phase, "/R4"}, exp_d, exp_oe);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    for (int i = 0; i < 4096; i++) begin
      capv[i] = 0; sv[i] = 0; sd[i] = '0; ma[i] = '0;
    end
    k = 2; lcur = 2; nbeat = 1; exp_d = '0; exp_oe = '0;
    rst = 1'b1; cke = 1'b1; rd_valid = 1'b1; rd_data = 32'hFFFF_FFFF; byte_mask = 4'h0; lat_sel = 1'b1;
    repeat (3) @(negedge clk);
    // R8: reset clears outputs
    check("R8", 32'h0, 4'h0);
    rst = 1'b0;

    // R7: idle keeps outputs quiet, R1 with every mask value
    phase = "R7";
    repeat (3) step(1, 0, 4'h0, 0);
    phase = "R1/R3";
    for (int m = 0; m < 16; m++) begin
      step(1, 1, 4'(m), 0);
      repeat (3) step(1, 0, 4'(m), 0);
    end
    // R2 with every mask value
    phase = "R2/R3";
    for (int m = 0; m < 16; m++) begin
      step(1, 1, 4'(m), 1);
      repeat (3) step(1, 0, 4'(m), 1);
    end
    // R5: gapless bursts at both latencies
    phase = "R5";
    for (int l = 0; l < 2; l++) begin
      repeat (8) step(1, 1, 4'h0, 1'(l));
      repeat (4) step(1, 0, 4'h0, 1'(l));
      for (int i = 0; i < 8; i++) step(1, 1, 4'(i * 5), 1'(l));
      repeat (4) step(1, 0, 4'h0, 1'(l));
    end
    // R6: setting flipped while beats are in flight
    phase = "R6";
    step(1, 1, 4'h0, 0);
    step(1, 0, 4'h0, 1);
    step(1, 1, 4'h0, 1);
    step(1, 1, 4'h0, 0);
    repeat (5) step(1, 0, 4'h0, 1);
    step(1, 1, 4'h0, 0);
    repeat (4) step(1, 0, 4'h0, 0);
    // R4: suspended edges mixed into streams
    phase = "R4";
    lf = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(lf[1:0] != 2'b00, lf[4] | lf[7], lf[11:8], 1'(i >= 200));
    end
    // mixed traffic, all inputs varying
    phase = "R1/R2/R3/R6";
    for (int i = 0; i < 800; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(lf[2:0] != 3'b000, lf[5], lf[12:9], lf[14] & lf[3]);
    end
    phase = "R7";
    repeat (4) step(1, 0, 4'h0, 0);

    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule